// File: doc/BRIEF.md
# CAN Fault-Confinement Counters with Bus-Off Recovery

This block keeps the transmit and receive error counts of a CAN node and, from them, decides which fault-confinement state the node is in: error active, error passive or bus-off. The protocol engine feeds it single-cycle event pulses: transmit error, receive error, transmit success, receive success, and a pulse each time a run of 11 consecutive recessive bits has been seen on the bus. It reports both counters, the state, and two interrupt-style flag pulses. A standby request clears it in the same way a reset does.

The state machine has three states. FC_ACTIVE (code 0) and FC_PASSIVE (code 1) move between each other as the counters cross 127 in either direction (transitions *go_passive* and *go_active*). Any transmit error that would push the transmit count above 255 takes the node to FC_BUSOFF (code 2, transition *enter_busoff*). While in bus-off the frame events are ignored and the receive counter is reused to count 11-recessive-bit runs: at 96 runs a warning pulse fires and a sticky warning status is set, and at 128 runs a recovery pulse fires. On the following cycle both counters are cleared and the machine returns to FC_ACTIVE (transition *recover*).

Top module: `can_fault_confine`

## Requirements
- R1: After reset or during a cycle with `standby_i` high, both counters read 0, the state reads 0 (active), and `warn_o`, `recov_o` and `warn_sts_o` are low; the values appear on the cycle after the standby request is sampled.
- R2: Outside bus-off, a receive error adds 1 to `rec_o` and a receive success subtracts 1; `rec_o` never goes below 0 and saturates at 255 rather than wrapping.
- R3: Outside bus-off, a transmit error adds 8 to `tec_o` and a transmit success subtracts 1, never going below 0.
- R4: Outside bus-off, `state_o` is 1 (passive) when either counter is above 127 and 0 (active) when both are 127 or below, in the same cycle the counters show the new values.
- R5: A transmit error that would make `tec_o` exceed 255 moves `state_o` to 2 (bus-off); in that same update `tec_o` shows the sum (above 255) and `rec_o` is cleared to 0.
- R6: In bus-off, transmit and receive error and success pulses change neither counter; each `rcsv11_i` pulse adds 1 to `rec_o`.
- R7: When `rec_o` becomes 96 in bus-off, `warn_o` is high for exactly that one cycle, and `warn_sts_o` goes high then and stays high until recovery completes.
- R8: When `rec_o` becomes 128 in bus-off, `recov_o` is high for that one cycle; on the next cycle both counters are 0, `state_o` is 0 and `warn_sts_o` is low, and an `rcsv11_i` pulse in that cycle has no effect.
- R9: If an error and a success pulse for the same counter arrive in the same cycle, only the error is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous clear of all state (standby entry) |
| tx_err_i | input | 1 | Transmit error event pulse |
| rx_err_i | input | 1 | Receive error event pulse |
| tx_ok_i | input | 1 | Successful transmission pulse |
| rx_ok_i | input | 1 | Successful reception pulse |
| rcsv11_i | input | 1 | End of an 11-recessive-bit run pulse |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter / bus-off run counter |
| state_o | output | 2 | 0 active, 1 passive, 2 bus-off |
| warn_o | output | 1 | One-cycle pulse at 96 runs in bus-off |
| warn_sts_o | output | 1 | Sticky warning status, cleared on recovery |
| recov_o | output | 1 | One-cycle pulse at 128 runs in bus-off |

## Verification
The bench drives the receive counter to 255 and beyond, where a design that wraps would fall back to 0 and drop out of the passive state, and takes both counters down to 0, where a missing floor would underflow to a large passive value. It crosses 127 in both directions and lands exactly on the 248-to-256 step that enters bus-off, where an off-by-one limit would keep the node passive or enter bus-off a frame early, and it checks that the receive count left over from before is cleared. Inside bus-off it sends frame events that must be ignored, checks that the warning pulse lasts a single cycle at exactly 96, and sends a recessive-run pulse in the recovery cycle, which a design that keeps counting would turn into a count of 1 in place of a clean return to zero.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/can_fc_tec.sv
module can_fc_tec #(
    parameter int TEC_W      = 9,
    parameter int TX_ERR_INC = 8,
    parameter int OFF_LIM    = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             busoff_i,
    input  logic             recov_i,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    output logic [TEC_W-1:0] tec_q,
    output logic [TEC_W-1:0] tec_d,
    output logic             ovf_o
);
    localparam int SUM_W = TEC_W + 1;

    logic [SUM_W-1:0] sum;

    assign sum   = {1'b0, tec_q} + SUM_W'(TX_ERR_INC);
    assign ovf_o = !busoff_i && tx_err_i && (sum > SUM_W'(OFF_LIM));

    always_comb begin
        tec_d = tec_q;
        if (recov_i) begin
            tec_d = '0;
        end else if (!busoff_i) begin
            if (tx_err_i) begin
                tec_d = sum[TEC_W-1:0];
            end else if (tx_ok_i && tec_q != '0) begin
                tec_d = tec_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tec_q <= '0;
        end else if (standby_i) begin
            tec_q <= '0;
        end else begin
            tec_q <= tec_d;
        end
    end

    // R3: an error outside bus-off adds the fixed step
    p_tec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!standby_i && !busoff_i && !recov_i && tx_err_i)
        |=> (32'(tec_q) == 32'($past(tec_q)) + TX_ERR_INC));

    // R3: a zero count stays at zero when only successes arrive
    p_tec_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_q == '0 && !tx_err_i) |=> (tec_q == '0));

    // R6: frame events do not move the count in bus-off
    p_tec_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_i && !recov_i && !standby_i) |=> $stable(tec_q));
endmodule

// File: rtl/can_fc_rec.sv
module can_fc_rec #(
    parameter int REC_W     = 8,
    parameter int WARN_CNT  = 96,
    parameter int RECOV_CNT = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             busoff_i,
    input  logic             enter_i,
    input  logic             recov_i,
    input  logic             rx_err_i,
    input  logic             rx_ok_i,
    input  logic             rcsv11_i,
    output logic [REC_W-1:0] rec_q,
    output logic [REC_W-1:0] rec_d,
    output logic             warn_hit_o,
    output logic             recov_hit_o
);
    localparam logic [REC_W-1:0] REC_MAX = {REC_W{1'b1}};
    localparam logic [REC_W-1:0] WARN_PRE  = REC_W'(WARN_CNT - 1);
    localparam logic [REC_W-1:0] RECOV_PRE = REC_W'(RECOV_CNT - 1);
    localparam logic [REC_W-1:0] RECOV_V   = REC_W'(RECOV_CNT);

    assign warn_hit_o  = busoff_i && !recov_i && rcsv11_i && (rec_q == WARN_PRE);
    assign recov_hit_o = busoff_i && !recov_i && rcsv11_i && (rec_q == RECOV_PRE);

    always_comb begin
        rec_d = rec_q;
        if (recov_i || enter_i) begin
            rec_d = '0;
        end else if (busoff_i) begin
            if (rcsv11_i && rec_q < RECOV_V) begin
                rec_d = rec_q + 1'b1;
            end
        end else if (rx_err_i) begin
            if (rec_q != REC_MAX) begin
                rec_d = rec_q + 1'b1;
            end
        end else if (rx_ok_i && rec_q != '0) begin
            rec_d = rec_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rec_q <= '0;
        end else if (standby_i) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    // R2: the count never wraps from its maximum outside bus-off
    p_rec_no_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busoff_i && !enter_i && !recov_i && !standby_i && rec_q == REC_MAX)
        |=> (rec_q >= REC_MAX - 1'b1));

    // R5: entering bus-off leaves the count at zero
    p_rec_enter_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enter_i && !standby_i) |=> (rec_q == '0));

    // R6: without a recessive-run pulse the bus-off count holds
    p_rec_bo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_i && !recov_i && !standby_i && !rcsv11_i) |=> $stable(rec_q));
endmodule

// File: rtl/can_fc_fsm.sv
module can_fc_fsm
    import can_fc_pkg::*;
#(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int PASSIVE_LIM = 127,
    parameter int WARN_CNT    = 96,
    parameter int RECOV_CNT   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic [TEC_W-1:0] tec_q,
    input  logic [TEC_W-1:0] tec_d,
    input  logic [REC_W-1:0] rec_q,
    input  logic [REC_W-1:0] rec_d,
    input  logic             ovf_i,
    input  logic             warn_hit_i,
    input  logic             recov_hit_i,
    output fc_state_e        state_q,
    output logic             recov_done_o,
    output logic             warn_o,
    output logic             warn_sts_o,
    output logic             recov_o
);
    localparam logic [REC_W-1:0] RECOV_V = REC_W'(RECOV_CNT);
    localparam logic [REC_W-1:0] WARN_V  = REC_W'(WARN_CNT);

    fc_state_e state_d;
    logic      over_lim;

    assign recov_done_o = (state_q == FC_BUSOFF) && (rec_q == RECOV_V);
    assign over_lim     = (32'(tec_d) > PASSIVE_LIM) || (32'(rec_d) > PASSIVE_LIM);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE, FC_PASSIVE: begin
                if (ovf_i) begin
                    state_d = FC_BUSOFF;      // enter_busoff
                end else if (over_lim) begin
                    state_d = FC_PASSIVE;     // go_passive
                end else begin
                    state_d = FC_ACTIVE;      // go_active
                end
            end
            FC_BUSOFF: begin
                if (recov_done_o) begin
                    state_d = FC_ACTIVE;      // recover
                end
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_ACTIVE;
        end else if (standby_i) begin
            state_q <= FC_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_o     <= 1'b0;
            recov_o    <= 1'b0;
            warn_sts_o <= 1'b0;
        end else if (standby_i) begin
            warn_o     <= 1'b0;
            recov_o    <= 1'b0;
            warn_sts_o <= 1'b0;
        end else begin
            warn_o  <= warn_hit_i;
            recov_o <= recov_hit_i;
            if (recov_done_o) begin
                warn_sts_o <= 1'b0;
            end else if (warn_hit_i) begin
                warn_sts_o <= 1'b1;
            end
        end
    end

    // R4: outside bus-off the state follows the counter limits
    p_passive_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != FC_BUSOFF)
        |-> ((state_q == FC_PASSIVE) ==
             ((32'(tec_q) > PASSIVE_LIM) || (32'(rec_q) > PASSIVE_LIM))));

    // R7: the warning pulse is one cycle long and lands on the count
    p_warn_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |-> (state_q == FC_BUSOFF && rec_q == WARN_V && warn_sts_o));
    p_warn_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        warn_o |=> !warn_o);

    // R8: recovery pulse is followed by a clean active state
    p_recov_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        recov_o |=> (state_q == FC_ACTIVE && tec_q == '0 && rec_q == '0 && !warn_sts_o));

    // R5: bus-off is only entered with the transmit count past its limit
    p_busoff_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == FC_BUSOFF) |-> (32'(tec_q) > 255));
endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
    import can_fc_pkg::*;
#(
    parameter int TEC_W       = 9,
    parameter int REC_W       = 8,
    parameter int TX_ERR_INC  = 8,
    parameter int PASSIVE_LIM = 127,
    parameter int OFF_LIM     = 255,
    parameter int WARN_CNT    = 96,
    parameter int RECOV_CNT   = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby_i,
    input  logic             tx_err_i,
    input  logic             rx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_ok_i,
    input  logic             rcsv11_i,
    output logic [TEC_W-1:0] tec_o,
    output logic [REC_W-1:0] rec_o,
    output logic [1:0]       state_o,
    output logic             warn_o,
    output logic             warn_sts_o,
    output logic             recov_o
);
    fc_state_e        state_q;
    logic             busoff;
    logic             recov_done;
    logic             ovf;
    logic             warn_hit;
    logic             recov_hit;
    logic [TEC_W-1:0] tec_q, tec_d;
    logic [REC_W-1:0] rec_q, rec_d;

    assign busoff = (state_q == FC_BUSOFF);

    can_fc_tec #(
        .TEC_W      (TEC_W),
        .TX_ERR_INC (TX_ERR_INC),
        .OFF_LIM    (OFF_LIM)
    ) u_tec (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .busoff_i  (busoff),
        .recov_i   (recov_done),
        .tx_err_i  (tx_err_i),
        .tx_ok_i   (tx_ok_i),
        .tec_q     (tec_q),
        .tec_d     (tec_d),
        .ovf_o     (ovf)
    );

    can_fc_rec #(
        .REC_W     (REC_W),
        .WARN_CNT  (WARN_CNT),
        .RECOV_CNT (RECOV_CNT)
    ) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_i   (standby_i),
        .busoff_i    (busoff),
        .enter_i     (ovf),
        .recov_i     (recov_done),
        .rx_err_i    (rx_err_i),
        .rx_ok_i     (rx_ok_i),
        .rcsv11_i    (rcsv11_i),
        .rec_q       (rec_q),
        .rec_d       (rec_d),
        .warn_hit_o  (warn_hit),
        .recov_hit_o (recov_hit)
    );

    can_fc_fsm #(
        .TEC_W       (TEC_W),
        .REC_W       (REC_W),
        .PASSIVE_LIM (PASSIVE_LIM),
        .WARN_CNT    (WARN_CNT),
        .RECOV_CNT   (RECOV_CNT)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .standby_i    (standby_i),
        .tec_q        (tec_q),
        .tec_d        (tec_d),
        .rec_q        (rec_q),
        .rec_d        (rec_d),
        .ovf_i        (ovf),
        .warn_hit_i   (warn_hit),
        .recov_hit_i  (recov_hit),
        .state_q      (state_q),
        .recov_done_o (recov_done),
        .warn_o       (warn_o),
        .warn_sts_o   (warn_sts_o),
        .recov_o      (recov_o)
    );

    assign tec_o   = tec_q;
    assign rec_o   = rec_q;
    assign state_o = state_q;
endmodule

// File: tb/test_can_fault_confine.sv
module test_can_fault_confine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       tx_err = 1'b0, rx_err = 1'b0, tx_ok = 1'b0, rx_ok = 1'b0, rcsv11 = 1'b0;
    logic [8:0] tec;
    logic [7:0] rec;
    logic [1:0] state;
    logic       warn, warn_sts, recov;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    can_fault_confine i_can_fault_confine (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby_i  (standby),
        .tx_err_i   (tx_err),
        .rx_err_i   (rx_err),
        .tx_ok_i    (tx_ok),
        .rx_ok_i    (rx_ok),
        .rcsv11_i   (rcsv11),
        .tec_o      (tec),
        .rec_o      (rec),
        .state_o    (state),
        .warn_o     (warn),
        .warn_sts_o (warn_sts),
        .recov_o    (recov)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // drive one cycle of events at a falling edge; outputs are updated at the next falling edge
    task automatic step(input logic te, input logic re, input logic to, input logic ro, input logic r11);
        tx_err = te; rx_err = re; tx_ok = to; rx_ok = ro; rcsv11 = r11;
        @(negedge clk);
        tx_err = 0; rx_err = 0; tx_ok = 0; rx_ok = 0; rcsv11 = 0;
    endtask

    task automatic do_standby();
        standby = 1'b1;
        @(negedge clk);
        standby = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "tec after reset", int'(tec), 0);
        chk("R1", "rec after reset", int'(rec), 0);
        chk("R1", "state after reset", int'(state), 0);
        chk("R1", "flags after reset", int'({warn, warn_sts, recov}), 0);
    endtask

    task automatic t_rx_basic();
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0);
        chk("R2", "rec after 3 errors", int'(rec), 3);
        step(0, 0, 0, 1, 0);
        chk("R2", "rec after success", int'(rec), 2);
        for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
        chk("R2", "rec floor", int'(rec), 0);
    endtask

    task automatic t_rx_sat();
        for (int i = 0; i < 127; i++) step(0, 1, 0, 0, 0);
        chk("R4", "state at rec 127", int'(state), 0);
        step(0, 1, 0, 0, 0);
        chk("R4", "state at rec 128", int'(state), 1);
        for (int i = 0; i < 132; i++) step(0, 1, 0, 0, 0);
        chk("R2", "rec saturated", int'(rec), 255);
        chk("R2", "state at saturation", int'(state), 1);
        for (int i = 0; i < 127; i++) step(0, 0, 0, 1, 0);
        chk("R4", "rec back to 128", int'(rec), 128);
        chk("R4", "still passive at 128", int'(state), 1);
        step(0, 0, 0, 1, 0);
        chk("R4", "active at 127", int'(state), 0);
        do_standby();
        chk("R1", "rec cleared by standby", int'(rec), 0);
    endtask

    task automatic t_tx_basic();
        step(1, 0, 0, 0, 0);
        chk("R3", "tec after error", int'(tec), 8);
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 0);
        chk("R3", "tec floor", int'(tec), 0);
        for (int i = 0; i < 16; i++) step(1, 0, 0, 0, 0);
        chk("R3", "tec after 16 errors", int'(tec), 128);
        chk("R4", "passive from tec", int'(state), 1);
        step(0, 0, 1, 0, 0);
        chk("R4", "active at tec 127", int'(state), 0);
    endtask

    task automatic t_same_cycle();
        do_standby();
        step(0, 1, 0, 1, 0);
        chk("R9", "rec with error and success", int'(rec), 1);
        step(1, 0, 1, 0, 0);
        chk("R9", "tec with error and success", int'(tec), 8);
        do_standby();
        chk("R1", "tec cleared by standby", int'(tec), 0);
        chk("R1", "state after standby", int'(state), 0);
    endtask

    task automatic t_busoff();
        do_standby();
        for (int i = 0; i < 5; i++) step(0, 1, 0, 0, 0);
        for (int i = 0; i < 31; i++) step(1, 0, 0, 0, 0);
        chk("R5", "tec before limit", int'(tec), 248);
        chk("R5", "passive before limit", int'(state), 1);
        step(1, 0, 0, 0, 0);
        chk("R5", "state bus-off", int'(state), 2);
        chk("R5", "tec past limit", int'(tec), 256);
        chk("R5", "rec cleared on entry", int'(rec), 0);
        step(1, 1, 0, 0, 0);
        step(0, 0, 1, 1, 0);
        chk("R6", "tec frozen", int'(tec), 256);
        chk("R6", "rec ignores frame events", int'(rec), 0);
        for (int i = 0; i < 95; i++) step(0, 0, 0, 0, 1);
        chk("R6", "rec counts runs", int'(rec), 95);
        chk("R7", "no warning at 95", int'(warn), 0);
        step(0, 0, 0, 0, 1);
        chk("R7", "warning at 96", int'(warn), 1);
        chk("R7", "status at 96", int'(warn_sts), 1);
        step(0, 0, 0, 0, 0);
        chk("R7", "warning one cycle", int'(warn), 0);
        chk("R7", "status held", int'(warn_sts), 1);
        for (int i = 0; i < 31; i++) step(0, 0, 0, 0, 1);
        chk("R8", "rec at 127", int'(rec), 127);
        chk("R8", "no recovery at 127", int'(recov), 0);
        step(0, 0, 0, 0, 1);
        chk("R8", "recovery pulse", int'(recov), 1);
        chk("R8", "rec at 128", int'(rec), 128);
        chk("R8", "still bus-off", int'(state), 2);
        step(0, 0, 0, 0, 1);
        chk("R8", "state recovered", int'(state), 0);
        chk("R8", "tec cleared", int'(tec), 0);
        chk("R8", "rec cleared, run ignored", int'(rec), 0);
        chk("R8", "status cleared", int'(warn_sts), 0);
        chk("R8", "pulse one cycle", int'(recov), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rx_basic();
        t_rx_sat();
        t_tx_basic();
        t_same_cycle();
        t_busoff();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule